// File: doc/BRIEF.md
# Six-Channel Decimating Word Sequencer

The block takes a stream of 10-bit straight-binary words from a single parallel bus and distributes them, one word per active clock edge, over six channels. Each channel has a two-stage latch: a load stage that fills word by word, and an output stage that presents the channel code downstream. A start strobe arms a new loading pass, and the pass then walks the channels either upward from channel 0 or downward from channel 5. A separate transfer strobe copies all six load-stage values into the output stage at once. Several such blocks can therefore fill in turn from one bus and update their outputs in the same cycle.

The active edge for loading is chosen by an edge-select input: rising edges when it is high, falling edges when it is low. The transfer strobe is always sampled on a rising edge, and the copy happens on the falling edge that follows. An invert input is carried to every channel as a registered polarity flag, so a downstream converter can place its output above or below the midpoint reference.

Top module: `seqdrv_top`

## Requirements
- R1: While reset is held, and right after it is released, every channel code reads 0 and every polarity flag reads 0.
- R2: With `edge_rise` high, words are captured on rising clock edges. With `dir_rtl` low, the first word of a pass goes to channel 0, the next to channel 1, and so on up to channel 5.
- R3: With `edge_rise` low, words are captured on falling clock edges, in the same channel order as R2.
- R4: A pass begins only on an active edge where `start_seq` was high on the previous active edge of the same polarity. The word on the bus at that beginning edge is the first word of the pass.
- R5: With `dir_rtl` high at the beginning of a pass, the first word goes to channel 5, the next to channel 4, and so on down to channel 0.
- R6: After six words have been loaded the pass stops. Later active edges without a new start leave all load-stage values unchanged.
- R7: When `xfer` is high on a rising edge, all six load-stage values appear on `ch_codes` after the next falling edge. Channel k occupies bits [10k+9:10k]. At any other falling edge the codes hold.
- R8: When a falling-edge load and a transfer land on the same falling edge, the output stage gets the load-stage value from before that load.
- R9: Each falling edge copies `invert` into all six bits of `ch_pol`.
- R10: `dir_rtl` is taken only at the beginning of a pass. Changing it during a pass does not alter the channel order of that pass.
- R11: The block accepts one new word on every active edge, with no idle edges between the words of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock; both edges are used |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| din | input | 10 | Input word, straight binary, bit 9 is the MSB |
| start_seq | input | 1 | Arms a new loading pass for the next active edge |
| xfer | input | 1 | Sampled on a rising edge; commits all channels on the next falling edge |
| edge_rise | input | 1 | 1: load on rising edges; 0: load on falling edges |
| dir_rtl | input | 1 | 0: fill from channel 0 upward; 1: fill from channel 5 downward |
| invert | input | 1 | Polarity request passed to every channel |
| ch_codes | output | 60 | Output-stage codes; channel k in bits [10k+9:10k] |
| ch_pol | output | 6 | Polarity flag for each channel |

## Verification
The bench fills passes in both edge modes and both directions. A swapped edge mode would capture shifted or doubled words, and a wrong direction would show up as mirrored codes. It drives extra words after a finished pass and then transfers again; a sequencer that fails to stop would overwrite channels from the start of the bank. In falling-edge mode it times a transfer to coincide with a load, so a design that forwards the fresh word shows the new value on that channel instead of the old one. It also flips the direction partway through a pass, which a design that does not hold the direction would answer with a broken channel order.

// File: rtl/seqdrv_pkg.sv
package seqdrv_pkg;
  parameter int unsigned CODE_W = 10;
  parameter int unsigned NUM_CH = 6;
endpackage

// File: rtl/seqdrv_rst_sync.sv
module seqdrv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/seqdrv_load_seq.sv
module seqdrv_load_seq #(
  parameter int unsigned W       = 10,
  parameter int unsigned N       = 6,
  parameter bit          RISING  = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic           start_seq,
  input  logic           edge_rise,
  input  logic           dir_rtl,
  input  logic [N-1:0]   peer_tog,
  output logic [N*W-1:0] bank,
  output logic [N-1:0]   tog
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

  logic           start_q, start_d;
  logic           run_q, run_d;
  logic           dir_q, dir_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [N*W-1:0] bank_q, bank_d;
  logic [N-1:0]   tog_q, tog_d;
  logic           mode_ok, begin_now, wr_en;
  logic [SW-1:0]  slot;

  assign mode_ok   = RISING ? edge_rise : !edge_rise;
  assign begin_now = start_q && mode_ok;

  // next-state logic
  always_comb begin
    start_d = start_seq;
    run_d   = run_q;
    dir_d   = dir_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    slot    = '0;
    if (begin_now) begin
      wr_en = 1'b1;
      dir_d = dir_rtl;
      slot  = dir_rtl ? SW'(N - 1) : '0;
      cnt_d = CW'(1);
      run_d = (N > 1);
    end else if (run_q) begin
      wr_en = 1'b1;
      slot  = dir_q ? SW'(N - 1 - int'(cnt_q)) : SW'(cnt_q);
      cnt_d = cnt_q + CW'(1);
      run_d = (int'(cnt_q) + 1 < N);
    end
    bank_d = bank_q;
    tog_d  = tog_q;
    if (wr_en) begin
      bank_d[int'(slot)*W +: W] = din;
      tog_d[slot] = RISING ? ~peer_tog[slot] : peer_tog[slot];
    end
  end

  // registers, on the edge this instance serves
  generate
    if (RISING) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          start_q <= 1'b0;
          run_q   <= 1'b0;
          dir_q   <= 1'b0;
          cnt_q   <= '0;
          bank_q  <= '0;
          tog_q   <= '0;
        end else begin
          start_q <= start_d;
          run_q   <= run_d;
          dir_q   <= dir_d;
          cnt_q   <= cnt_d;
          if (wr_en) begin
            bank_q <= bank_d;
            tog_q  <= tog_d;
          end
        end
      end

      assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(cnt_q) < N));
      assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !begin_now) |=> $stable(bank_q));
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          start_q <= 1'b0;
          run_q   <= 1'b0;
          dir_q   <= 1'b0;
          cnt_q   <= '0;
          bank_q  <= '0;
          tog_q   <= '0;
        end else begin
          start_q <= start_d;
          run_q   <= run_d;
          dir_q   <= dir_d;
          cnt_q   <= cnt_d;
          if (wr_en) begin
            bank_q <= bank_d;
            tog_q  <= tog_d;
          end
        end
      end

      assert_cnt_range_R6: assert property (@(negedge clk) disable iff (!rst_n)
        run_q |-> (int'(cnt_q) < N));
      assert_idle_hold_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (!run_q && !begin_now) |=> $stable(bank_q));
    end
  endgenerate

  assign bank = bank_q;
  assign tog  = tog_q;
endmodule

// File: rtl/seqdrv_out_stage.sv
module seqdrv_out_stage #(
  parameter int unsigned W = 10,
  parameter int unsigned N = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer,
  input  logic           invert,
  input  logic [N*W-1:0] load_vals,
  output logic [N*W-1:0] codes,
  output logic [N-1:0]   pol
);
  logic           xfer_q;
  logic [N*W-1:0] codes_q, codes_d;
  logic [N-1:0]   pol_q, pol_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_q <= 1'b0;
    else        xfer_q <= xfer;
  end

  always_comb begin
    codes_d = xfer_q ? load_vals : codes_q;
    pol_d   = {N{invert}};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
      pol_q   <= '0;
    end else begin
      if (xfer_q) codes_q <= codes_d;
      pol_q <= pol_d;
    end
  end

  assign codes = codes_q;
  assign pol   = pol_q;

  assert_hold_R7: assert property (@(negedge clk) disable iff (!rst_n)
    !xfer_q |=> $stable(codes));
  assert_commit_R8: assert property (@(negedge clk) disable iff (!rst_n)
    xfer_q |=> (codes == $past(load_vals)));
  assert_pol_R9: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> (pol == {N{$past(invert)}}));
endmodule

// File: rtl/seqdrv_top.sv
module seqdrv_top
  import seqdrv_pkg::*;
#(
  parameter int unsigned W = CODE_W,
  parameter int unsigned N = NUM_CH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic           start_seq,
  input  logic           xfer,
  input  logic           edge_rise,
  input  logic           dir_rtl,
  input  logic           invert,
  output logic [N*W-1:0] ch_codes,
  output logic [N-1:0]   ch_pol
);
  logic           rst_n_s;
  logic [N*W-1:0] bank_r, bank_f, load_vals;
  logic [N-1:0]   tog_r, tog_f;

  seqdrv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  seqdrv_load_seq #(.W(W), .N(N), .RISING(1'b1)) u_seq_rise (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .din       (din),
    .start_seq (start_seq),
    .edge_rise (edge_rise),
    .dir_rtl   (dir_rtl),
    .peer_tog  (tog_f),
    .bank      (bank_r),
    .tog       (tog_r)
  );

  seqdrv_load_seq #(.W(W), .N(N), .RISING(1'b0)) u_seq_fall (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .din       (din),
    .start_seq (start_seq),
    .edge_rise (edge_rise),
    .dir_rtl   (dir_rtl),
    .peer_tog  (tog_r),
    .bank      (bank_f),
    .tog       (tog_f)
  );

  // per channel: the bank written last owns the load-stage value
  generate
    for (genvar k = 0; k < N; k++) begin : g_pick
      assign load_vals[k*W +: W] = (tog_r[k] ^ tog_f[k]) ? bank_r[k*W +: W]
                                                         : bank_f[k*W +: W];
    end
  endgenerate

  seqdrv_out_stage #(.W(W), .N(N)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .xfer      (xfer),
    .invert    (invert),
    .load_vals (load_vals),
    .codes     (ch_codes),
    .pol       (ch_pol)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n_s |-> (ch_codes == '0 && ch_pol == '0));
endmodule

// File: tb/sim_seqdrv_top.sv
module sim_seqdrv_top;
  localparam int W = 10;
  localparam int N = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   din;
  logic           start_seq, xfer, edge_rise, dir_rtl, invert;
  logic [N*W-1:0] ch_codes;
  logic [N-1:0]   ch_pol;

  int tests = 0;
  int fails = 0;

  logic [N*W-1:0] exp_q[$];
  string          tag_q[$];
  logic [W-1:0]   model [N];
  bit             done = 1'b0;

  always #2.5 clk = ~clk;

  seqdrv_top u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .start_seq(start_seq), .xfer(xfer),
    .edge_rise(edge_rise), .dir_rtl(dir_rtl), .invert(invert),
    .ch_codes(ch_codes), .ch_pol(ch_pol)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // settle to just after the edge opposite to the loading edge
  task automatic wait_drv(input bit rise);
    if (rise) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  function automatic logic [N*W-1:0] pack_model();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = model[k];
    return v;
  endfunction

  task automatic do_xfer(input string tag);
    xfer = 1'b1;
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    #1 xfer = 1'b0;
  endtask

  // one full pass; flip toggles dir_rtl after the third word
  task automatic run_pass(input bit rise, input bit d, input logic [W-1:0] w [N],
                          input bit flip, input string tag);
    edge_rise = rise;
    dir_rtl   = d;
    wait_drv(rise);
    start_seq = 1'b1;
    wait_drv(rise);
    start_seq = 1'b0;
    din = w[0];
    for (int i = 1; i < N; i++) begin
      wait_drv(rise);
      din = w[i];
      if (flip && i == 2) dir_rtl = ~d;
    end
    wait_drv(rise);
    for (int i = 0; i < N; i++) model[d ? N-1-i : i] = w[i];
    do_xfer(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      bit seen;
      @(posedge clk);
      seen = xfer;
      @(negedge clk);
      #2;
      if (seen && exp_q.size() > 0) begin
        logic [N*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int k = 0; k < N; k++)
          check($sformatf("%s ch%0d", t, k), 64'(ch_codes[k*W +: W]), 64'(e[k*W +: W]));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] wa [N];
    logic [W-1:0] wb [N];
    logic [W-1:0] wc [N];
    rst_n = 1'b0; din = '0; start_seq = 1'b0; xfer = 1'b0;
    edge_rise = 1'b1; dir_rtl = 1'b0; invert = 1'b0;
    for (int k = 0; k < N; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 codes in reset", 64'(ch_codes), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 codes after reset", 64'(ch_codes), 64'(0));
    check("R1 pol after reset", 64'(ch_pol), 64'(0));

    for (int i = 0; i < N; i++) begin
      wa[i] = W'(10'h041 + 10'(i * 97));
      wb[i] = W'(10'h3F0 - 10'(i * 53));
      wc[i] = W'(10'h200 + 10'(i * 3));
    end

    // R2 R4 R11: rising edges, upward
    run_pass(1'b1, 1'b0, wa, 1'b0, "R2");
    // R5: rising edges, downward
    run_pass(1'b1, 1'b1, wb, 1'b0, "R5");
    // R6: stray words with no start are ignored
    for (int i = 0; i < 3; i++) begin
      wait_drv(1'b1);
      din = 10'h155;
    end
    wait_drv(1'b1);
    do_xfer("R6");
    // R3: falling edges, upward
    run_pass(1'b0, 1'b0, wc, 1'b0, "R3");
    // R10: direction flipped mid-pass
    run_pass(1'b1, 1'b0, wb, 1'b1, "R10");

    // R8: falling-edge load and transfer on the same edge
    edge_rise = 1'b0; dir_rtl = 1'b0;
    wait_drv(1'b0);
    start_seq = 1'b1;
    wait_drv(1'b0);
    start_seq = 1'b0;
    din = wa[0];
    wait_drv(1'b0);
    din = wa[1];
    xfer = 1'b1;
    model[0] = wa[0];
    model[1] = wa[1];
    exp_q.push_back(pack_model());
    tag_q.push_back("R8");
    wait_drv(1'b0);
    xfer = 1'b0;
    din = wa[2];
    for (int i = 3; i < N; i++) begin
      wait_drv(1'b0);
      din = wa[i];
    end
    wait_drv(1'b0);
    for (int i = 0; i < N; i++) model[i] = wa[i];
    do_xfer("R8 complete");

    // R9: polarity follows invert
    invert = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R9 pol set", 64'(ch_pol), 64'(6'h3F));
    invert = 1'b0;
    repeat (2) @(negedge clk);
    #1 check("R9 pol clear", 64'(ch_pol), 64'(0));

    // R7: codes hold with no transfer
    repeat (4) @(negedge clk);
    #1 check("R7 hold", 64'(ch_codes), 64'(pack_model()));
    check("R7 queue drained", 64'(exp_q.size()), 64'(0));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule